// File: doc/BRIEF.md
# Float24 Constant Vector Loader

The loader takes a stream of 32-bit words on a single write port and builds four-component vectors of 24-bit floating-point values from them. Each completed vector goes into an indexed constant memory that a downstream consumer reads. After every store the destination index moves to the next slot, so a run of vectors can be loaded with a single index write.

Two input encodings are supported, and the mode is chosen together with the index. In packed mode three words hold four 24-bit values end to end. In float32 mode four IEEE single-precision words arrive and each one is narrowed to the 24-bit format. The 24-bit format has 1 sign bit, a 7-bit exponent with bias 63 and a 16-bit mantissa.

A write to an index at or beyond the memory depth is dropped and reported with a one-cycle error pulse. A registered read port returns any stored vector.

Top module: `f24_vec_loader`

## Requirements
- R1: In packed mode (mode bit 0) the vector is stored on the edge that accepts the third data word. The stored 96-bit value equals {word0, word1, word2}. Component x occupies bits 23:0, y bits 47:24, z bits 71:48 and w bits 95:72.
- R2: In float32 mode (mode bit 1) the vector is stored on the edge that accepts the fourth data word. The converted word k lands in component 3-k, so word0 goes to w (bits 95:72) and word3 goes to x (bits 23:0).
- R3: A float32 word whose exponent field e satisfies 64 < e < 192 converts to {sign, e-64 in 7 bits, mantissa bits 22:7}. The low 7 mantissa bits are truncated.
- R4: A float32 word with exponent field 64 or below, including zeros and denormals, converts to its sign followed by 23 zero bits.
- R5: A float32 word with exponent field 192 or above, including infinities and NaNs, saturates to its sign followed by exponent 7'h7F and mantissa 16'hFFFF.
- R6: Each stored vector increments the current index (`cur_idx`) by one on the same edge.
- R7: If the current index is DEPTH (96) or more when a vector completes, nothing is stored and the index stays the same. `drop_err` is high for exactly the one cycle after that edge.
- R8: An index write loads the index and the mode and discards any partially collected words. If a data word arrives in the same cycle as an index write, the data word is ignored.
- R9: `rd_data` shows the vector stored at `rd_idx` one clock after `rd_idx` is presented. In reset, `cur_idx`, `drop_err` and `rd_data` clear to zero and the mode returns to packed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr_en | input | 1 | Load index and mode |
| idx_wr_val | input | IDX_W | New destination index |
| idx_wr_f32 | input | 1 | Mode: 0 packed, 1 float32 |
| word_wr_en | input | 1 | Data word strobe |
| word_wr_data | input | 32 | Data word |
| rd_idx | input | AW | Read address |
| rd_data | output | 96 | Registered vector {w,z,y,x} |
| cur_idx | output | IDX_W | Current destination index |
| drop_err | output | 1 | Pulse for a dropped out-of-range vector |

## Verification
Several properties are checked every cycle by assertions. The word counter never exceeds the count that belongs to the current mode, and it returns to zero after an index write or a completed vector. The index advances by exactly one per stored vector, stays put when a vector is dropped, and the error pulse never lasts two cycles. Only the bench scenarios can show the correct value in each memory slot: the component order, the float32 narrowing at the underflow and overflow limits, the discarding of partial words, and the precedence of index writes. The bench compares these against a behavioural model on every clock.

// File: rtl/f24_pkg.sv
package f24_pkg;
  localparam int WORD_W  = 32;
  localparam int F24_W   = 24;
  localparam int NCOMP   = 4;
  localparam int VEC_W   = F24_W * NCOMP;
  localparam int PACKED_WORDS = (VEC_W + WORD_W - 1) / WORD_W;
  localparam int F32_WORDS    = NCOMP;

  typedef logic [F24_W-1:0]  f24_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    f24_t w;
    f24_t z;
    f24_t y;
    f24_t x;
  } f24_vec_t;
endpackage

// File: rtl/f32_to_f24.sv
module f32_to_f24
  import f24_pkg::*;
#(
  parameter int SRC_BIAS  = 127,
  parameter int DST_BIAS  = 63,
  parameter int DST_EXP_W = 7
) (
  input  word_t f32_i,
  output f24_t  f24_o
);
  localparam int SRC_EXP_W = 8;
  localparam int DST_MAN_W = F24_W - 1 - DST_EXP_W;
  localparam int SRC_MAN_W = WORD_W - 1 - SRC_EXP_W;
  localparam int SHIFT     = SRC_BIAS - DST_BIAS;
  localparam int EXP_HI    = SHIFT + (1 << DST_EXP_W);
  localparam logic [SRC_EXP_W-1:0] LO_LIM = SRC_EXP_W'(SHIFT);
  localparam logic [SRC_EXP_W-1:0] HI_LIM = SRC_EXP_W'(EXP_HI);

  logic                 sign;
  logic [SRC_EXP_W-1:0] exp_in;
  logic [SRC_EXP_W-1:0] exp_reb;
  logic [DST_MAN_W-1:0] man_keep;
  logic                 unused_lsb;

  assign sign     = f32_i[WORD_W-1];
  assign exp_in   = f32_i[WORD_W-2 -: SRC_EXP_W];
  assign man_keep = f32_i[SRC_MAN_W-1 -: DST_MAN_W];
  assign exp_reb  = exp_in - LO_LIM;
  assign unused_lsb = ^f32_i[SRC_MAN_W-DST_MAN_W-1:0];

  always_comb begin
    if (exp_in <= LO_LIM) begin
      f24_o = {sign, {(F24_W-1){1'b0}}};
    end else if (exp_in >= HI_LIM) begin
      f24_o = {sign, {(F24_W-1){1'b1}}};
    end else begin
      f24_o = {sign, exp_reb[DST_EXP_W-1:0], man_keep};
    end
  end
endmodule

// File: rtl/f24_word_collector.sv
module f24_word_collector
  import f24_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_i,
  input  logic  wr_en_i,
  input  word_t wr_data_i,
  input  logic  mode_f32_i,
  output logic  commit_o,
  output word_t words_o [F32_WORDS]
);
  localparam int CNT_W = $clog2(F32_WORDS + 1);
  localparam int HOLD  = F32_WORDS - 1;
  localparam logic [CNT_W-1:0] LAST_PK  = CNT_W'(PACKED_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_F32 = CNT_W'(F32_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;
  word_t            hold_q [HOLD];
  logic             accept;
  logic             at_last;

  assign accept   = wr_en_i && !clr_i;
  assign at_last  = cnt_q == (mode_f32_i ? LAST_F32 : LAST_PK);
  assign commit_o = accept && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < HOLD; k++) begin
      if (accept && cnt_q == CNT_W'(k)) hold_q[k] <= wr_data_i;
    end
  end

  generate
    for (genvar g = 0; g < F32_WORDS; g++) begin : g_words
      if (g == F32_WORDS - 1) begin : g_tail
        assign words_o[g] = wr_data_i;
      end else if (g == PACKED_WORDS - 1) begin : g_pk_last
        assign words_o[g] = mode_f32_i ? hold_q[g] : wr_data_i;
      end else begin : g_held
        assign words_o[g] = hold_q[g];
      end
    end
  endgenerate

  a_r8_clear_counter: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_q == '0);
  a_r1_packed_bound: assert property (@(posedge clk) disable iff (rst)
    !mode_f32_i |-> cnt_q <= LAST_PK);
  a_r2_wrap_after_commit: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> cnt_q == '0);
endmodule

// File: rtl/f24_vec_assembler.sv
module f24_vec_assembler
  import f24_pkg::*;
(
  input  logic     mode_f32_i,
  input  word_t    words_i [F32_WORDS],
  output f24_vec_t vec_o
);
  f24_t conv [NCOMP];
  logic [VEC_W-1:0] packed_bits;
  logic [VEC_W-1:0] f32_bits;
  logic [PACKED_WORDS*WORD_W-1:0] cat;

  generate
    for (genvar g = 0; g < PACKED_WORDS; g++) begin : g_cat
      assign cat[(PACKED_WORDS-1-g)*WORD_W +: WORD_W] = words_i[g];
    end
    for (genvar g = 0; g < NCOMP; g++) begin : g_conv
      f32_to_f24 u_cvt (
        .f32_i (words_i[g]),
        .f24_o (conv[g])
      );
      assign f32_bits[(NCOMP-1-g)*F24_W +: F24_W] = conv[g];
    end
  endgenerate

  assign packed_bits = cat[PACKED_WORDS*WORD_W-1 -: VEC_W];
  assign vec_o = mode_f32_i ? f24_vec_t'(f32_bits) : f24_vec_t'(packed_bits);
endmodule

// File: rtl/f24_const_mem.sv
module f24_const_mem
  import f24_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [VEC_W-1:0] rdata_o
);
  logic [VEC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/f24_vec_loader.sv
module f24_vec_loader
  import f24_pkg::*;
#(
  parameter int DEPTH = 96,
  parameter int IDX_W = 7,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_wr_en,
  input  logic [IDX_W-1:0] idx_wr_val,
  input  logic             idx_wr_f32,
  input  logic             word_wr_en,
  input  logic [31:0]      word_wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [VEC_W-1:0] rd_data,
  output logic [IDX_W-1:0] cur_idx,
  output logic             drop_err
);
  logic     mode_f32_q;
  logic     commit;
  logic     in_range;
  logic     store;
  word_t    words [F32_WORDS];
  f24_vec_t vec;

  assign in_range = int'(cur_idx) < DEPTH;
  assign store    = commit && in_range;

  f24_word_collector u_collect (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (idx_wr_en),
    .wr_en_i    (word_wr_en),
    .wr_data_i  (word_wr_data),
    .mode_f32_i (mode_f32_q),
    .commit_o   (commit),
    .words_o    (words)
  );

  f24_vec_assembler u_asm (
    .mode_f32_i (mode_f32_q),
    .words_i    (words),
    .vec_o      (vec)
  );

  f24_const_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .we_i    (store),
    .waddr_i (cur_idx[AW-1:0]),
    .wdata_i (vec),
    .raddr_i (rd_idx),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx    <= '0;
      mode_f32_q <= 1'b0;
      drop_err   <= 1'b0;
    end else begin
      drop_err <= commit && !in_range;
      if (idx_wr_en) begin
        cur_idx    <= idx_wr_val;
        mode_f32_q <= idx_wr_f32;
      end else if (store) begin
        cur_idx <= cur_idx + 1'b1;
      end
    end
  end

  a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
    store |=> cur_idx == $past(cur_idx) + 1'b1);
  a_r7_index_hold: assert property (@(posedge clk) disable iff (rst)
    (commit && !in_range) |=> $stable(cur_idx));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    drop_err |=> !drop_err);
endmodule

// File: tb/f24_vec_loader_tb_top.sv
module f24_vec_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 96;
  localparam int IDX_W = 7;
  localparam int AW    = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             idx_wr_en = 1'b0;
  logic [IDX_W-1:0] idx_wr_val = '0;
  logic             idx_wr_f32 = 1'b0;
  logic             word_wr_en = 1'b0;
  logic [31:0]      word_wr_data = '0;
  logic [AW-1:0]    rd_idx = '0;
  logic [95:0]      rd_data;
  logic [IDX_W-1:0] cur_idx;
  logic             drop_err;

  f24_vec_loader #(.DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .idx_wr_en(idx_wr_en), .idx_wr_val(idx_wr_val),
    .idx_wr_f32(idx_wr_f32), .word_wr_en(word_wr_en), .word_wr_data(word_wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cur_idx(cur_idx), .drop_err(drop_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  string req_tag = "R1";

  int          m_idx;
  bit          m_f32;
  int          m_cnt;
  logic [31:0] m_w [4];
  logic [95:0] m_mem [int];
  logic [95:0] m_rd;
  bit          m_rd_known;
  bit          m_err;

  function automatic logic [23:0] ref_cvt(logic [31:0] f);
    int e;
    e = int'(f[30:23]);
    if (e <= 64)  return {f[31], 23'd0};
    if (e >= 192) return {f[31], 23'h7FFFFF};
    return {f[31], 7'(e - 64), f[22:7]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_f32 = 0; m_cnt = 0; m_err = 0; m_rd = '0; m_rd_known = 1;
    end else begin
      m_err = 0;
      if (m_mem.exists(int'(rd_idx))) begin
        m_rd = m_mem[int'(rd_idx)]; m_rd_known = 1;
      end else m_rd_known = 0;
      if (idx_wr_en) begin
        m_idx = int'(idx_wr_val); m_f32 = idx_wr_f32; m_cnt = 0;
      end else if (word_wr_en) begin
        m_w[m_cnt] = word_wr_data;
        m_cnt++;
        if (m_cnt == (m_f32 ? 4 : 3)) begin
          m_cnt = 0;
          if (m_idx < DEPTH) begin
            m_mem[m_idx] = m_f32 ?
              {ref_cvt(m_w[0]), ref_cvt(m_w[1]), ref_cvt(m_w[2]), ref_cvt(m_w[3])} :
              {m_w[0], m_w[1], m_w[2]};
            m_idx++;
          end else m_err = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (int'(cur_idx) != m_idx) begin
        n_bad++;
        $display("FAIL R6 index: actual=%0d expected=%0d", cur_idx, m_idx);
      end
      n_cmp++;
      if (drop_err !== m_err) begin
        n_bad++;
        $display("FAIL R7 drop pulse: actual=%0b expected=%0b", drop_err, m_err);
      end
      if (m_rd_known) begin
        n_cmp++;
        if (rd_data !== m_rd) begin
          n_bad++;
          $display("FAIL %s read slot %0d: actual=%h expected=%h", req_tag, rd_idx, rd_data, m_rd);
        end
      end
    end
  end

  task automatic set_index(input int idx, input bit f32);
    idx_wr_en = 1; idx_wr_val = IDX_W'(idx); idx_wr_f32 = f32;
    @(negedge clk);
    idx_wr_en = 0;
  endtask

  task automatic put_word(input logic [31:0] w);
    word_wr_en = 1; word_wr_data = w;
    @(negedge clk);
    word_wr_en = 0;
  endtask

  task automatic read_slot(input int a);
    rd_idx = AW'(a);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    n_cmp++;
    if (cur_idx !== '0 || drop_err !== 1'b0 || rd_data !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: actual=%0d/%0b/%h expected=0/0/0", cur_idx, drop_err, rd_data);
    end
    rst = 0;
    @(negedge clk);

    // R1: packed vectors with distinct patterns
    req_tag = "R1";
    set_index(0, 0);
    put_word(32'h11223344); put_word(32'h55667788); put_word(32'h99AABBCC);
    put_word(32'hFFFFFFFF); put_word(32'h00000000); put_word(32'hA5A5A5A5);
    put_word(32'h01020304); put_word(32'hDEADBEEF); put_word(32'h80000001);
    for (int i = 0; i < 3; i++) read_slot(i);

    // R2, R3, R4, R5: float32 vectors
    req_tag = "R2/R3";
    set_index(10, 1);
    put_word(32'h3F800000); put_word(32'hC0490FDB); put_word(32'h20800000); put_word(32'h5F800000);
    req_tag = "R4";
    put_word(32'h20000000); put_word(32'h00000001); put_word(32'h80000000); put_word(32'h3F8000FF);
    req_tag = "R5";
    put_word(32'h7F800000); put_word(32'h60000000); put_word(32'hFFC00000); put_word(32'h5FFFFFFF);
    req_tag = "R2";
    for (int i = 10; i < 13; i++) read_slot(i);

    // R8: partial words discarded by an index write
    req_tag = "R8";
    set_index(20, 0);
    put_word(32'hBAD0BAD0); put_word(32'hBAD1BAD1);
    set_index(20, 0);
    put_word(32'h0A0B0C0D); put_word(32'h10203040); put_word(32'h50607080);
    // R8: simultaneous index and data write, data dropped
    word_wr_en = 1; word_wr_data = 32'hCAFECAFE;
    set_index(30, 1);
    word_wr_en = 0;
    put_word(32'h3F800000); put_word(32'h40000000); put_word(32'h40400000); put_word(32'h40800000);
    read_slot(20); read_slot(21); read_slot(30);

    // R7: boundary at the top of the memory
    req_tag = "R7";
    set_index(94, 0);
    for (int i = 0; i < 9; i++) put_word(32'h01010101 * (i + 1));
    set_index(127, 1);
    for (int i = 0; i < 4; i++) put_word(32'h3F800000);
    read_slot(94); read_slot(95);

    // R6: mode switch back to packed continues stepping
    req_tag = "R6";
    set_index(40, 1);
    for (int i = 0; i < 4; i++) put_word(32'h40000000 + i);
    set_index(41, 0);
    for (int i = 0; i < 3; i++) put_word(32'h77777777 ^ i);
    read_slot(40); read_slot(41);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule